// File: doc/BRIEF.md
# Buffered Modulus Timebase Counter

This block is one counter channel whose value serves as a shared time base for neighbouring channels. It counts inside a window that starts at one and ends at a modulus value. The host may write a new modulus at any moment. That write lands in a staging register. The counter takes the staged value into its active modulus only at the cycle boundary, when the count arrives at one. A period change therefore never cuts a cycle short and never stretches one.

A 7-bit mode code picks the behaviour:
- a sawtooth that counts upward and wraps back to one;
- a triangle that turns downward at the modulus and turns upward again at one.

The mode code also chooses the count enable. The counter advances either on every system clock or on a chosen edge of an external pin, and the pin passes through a synchronizer first. A sticky flag marks match events and is cleared by a write-one strobe. If the mode code is reserved, the channel freezes. When a valid code comes back, counting resumes from the held value.

Top module: `tbc_chan`

## Requirements
- R1: Out of reset, `cnt_o` always satisfies 1 <= `cnt_o` <= `mod_act_o`.
- R2: A write on `mod_wr_i` updates only the staging register. `mod_act_o` takes the staged value at the clock edge where a count step makes `cnt_o` become 1, and changes at no other time.
- R3: Sawtooth codes are `mode_i` = 7'b1010000 and 7'b1010001. On each step, a count equal to `mod_act_o` becomes 1 and any other count increments. The period is `mod_act_o` steps and `dir_down_o` is 0.
- R4: Triangle codes are `mode_i` = 7'b10101xx. Counting up, a count equal to `mod_act_o` (when above 1) decrements and sets `dir_down_o`. Counting down, a count of 1 becomes 2 (or stays 1 when the modulus is 1) and clears `dir_down_o`. The period is 2×modulus−2 steps.
- R5: When a valid code is applied after a reserved one, the next step continues from the held `cnt_o`. Nothing reloads.
- R6: The flag-set event depends on the mode.
  - Sawtooth: a step taken while `cnt_o` equals `mod_act_o`.
  - Triangle with `mode_i[1]`=0: a step taken at count 1 only.
  - Triangle with `mode_i[1]`=1: a step at count 1 or a step at the modulus.
- R7: `mode_i[0]`=1 selects the external pin as the step source.
  - With `edge_both_i`=1, any pin change is a step.
  - Otherwise `edge_rise_i`=1 selects rising edges and 0 selects falling edges.
  - A pin level sampled at clock edge k first changes `cnt_o` at edge k+2.
  - With `mode_i[0]`=0, every clock is a step.
- R8: Every other `mode_i` code, including 7'b1010010 and 7'b1010011, is reserved. Under a reserved code, `cnt_o`, `dir_down_o` and `mod_act_o` hold.
- R9: `flag_o` stays set until a cycle with `flag_clr_i`=1 and no set event. A set event in the same cycle as a clear leaves the flag set.
- R10: After reset, `cnt_o`=1, `mod_act_o`=1, `dir_down_o`=0 and `flag_o`=0.
- R11: Writing 0 to the staging register stores 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 7 | Mode code; bit 0 external step, bit 1 both-event flag, bit 2 triangle |
| edge_both_i | input | 1 | External pin: step on both edges |
| edge_rise_i | input | 1 | External pin: 1 rising, 0 falling (when not both) |
| ext_pin_i | input | 1 | Asynchronous external count pin |
| mod_wr_i | input | 1 | Staging modulus write strobe |
| mod_wdata_i | input | CW | Staging modulus write data |
| flag_clr_i | input | 1 | Write-one-to-clear flag strobe |
| cnt_o | output | CW | Shared time base count |
| dir_down_o | output | 1 | 1 while counting down |
| flag_o | output | 1 | Sticky match flag |
| mod_act_o | output | CW | Active modulus |

## Verification
The checker assumes the following about the environment:
- reset is released away from a clock edge;
- `mode_i` changes only between edges;
- any modulus the host writes fits in `CW` bits.

Under those assumptions it treats the window invariant and the hold under reserved codes as unconditional. The wrap and turn-around properties are checked only under internal stepping, because there every clock is a step and a single-cycle implication is exact. The stimulus drives all inputs at falling clock edges, keeps modulus values small so that several full cycles fit in each phase, and toggles the pin at intervals of several clocks.

// File: rtl/tbc_pkg.sv
package tbc_pkg;

  localparam int unsigned MODE_W = 7;

  // upper four code bits shared by every valid code
  localparam logic [3:0] MODE_FAMILY = 4'b1010;

  typedef struct packed {
    logic valid;
    logic updown;
    logic both_ev;
    logic ext_clk;
  } mode_dec_t;

endpackage

// File: rtl/tbc_mode_dec.sv
module tbc_mode_dec
  import tbc_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  output mode_dec_t         dec_o
);

  logic family;
  logic saw_ok;
  logic tri_ok;

  always_comb begin
    family = (mode_i[6:3] == MODE_FAMILY);
    saw_ok = family && (mode_i[2:1] == 2'b00);
    tri_ok = family && mode_i[2];
    dec_o.valid   = saw_ok || tri_ok;
    dec_o.updown  = tri_ok;
    dec_o.both_ev = tri_ok && mode_i[1];
    dec_o.ext_clk = mode_i[0];
  end

endmodule

// File: rtl/tbc_edge_sync.sv
module tbc_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic sel_ext_i,
  input  logic both_i,
  input  logic rise_i,
  output logic tick_o
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;
  logic              prev_q;
  logic              prev_d;
  logic              synced;
  logic              rise_ev;
  logic              fall_ev;
  logic              pin_ev;

  always_comb begin
    sh_d   = {sh_q[STAGES-2:0], pin_i};
    synced = sh_q[STAGES-1];
    prev_d = synced;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      prev_q <= prev_d;
    end
  end

  always_comb begin
    rise_ev = synced && !prev_q;
    fall_ev = !synced && prev_q;
    if (both_i) begin
      pin_ev = rise_ev || fall_ev;
    end else if (rise_i) begin
      pin_ev = rise_ev;
    end else begin
      pin_ev = fall_ev;
    end
    tick_o = sel_ext_i ? pin_ev : 1'b1;
  end

endmodule

// File: rtl/tbc_modulus_buf.sv
module tbc_modulus_buf #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [CW-1:0] wdata_i,
  input  logic          load_i,
  output logic [CW-1:0] act_o
);

  logic [CW-1:0] stage_q, stage_d;
  logic [CW-1:0] act_q, act_d;
  logic          stage_en;
  logic          act_en;

  always_comb begin
    stage_en = wr_i;
    act_en   = load_i;
    stage_d  = (wdata_i == '0) ? CW'(1) : wdata_i;
    act_d    = stage_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= CW'(1);
      act_q   <= CW'(1);
    end else begin
      if (stage_en) stage_q <= stage_d;
      if (act_en)   act_q   <= act_d;
    end
  end

  assign act_o = act_q;

endmodule

// File: rtl/tbc_count_core.sv
module tbc_count_core #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  logic          updown_i,
  input  logic          both_ev_i,
  input  logic          flag_clr_i,
  input  logic [CW-1:0] mod_i,
  output logic          load_o,
  output logic [CW-1:0] cnt_o,
  output logic          dir_down_o,
  output logic          flag_o
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          dir_q, dir_d;
  logic          flag_q, flag_d;
  logic          at_top, at_one, mod_gt1;
  logic          top_ev, one_ev, set_ev;

  always_comb begin
    at_top  = (cnt_q >= mod_i);
    at_one  = (cnt_q == CW'(1));
    mod_gt1 = (mod_i > CW'(1));
    cnt_d   = cnt_q;
    dir_d   = dir_q;
    if (step_i) begin
      if (!updown_i) begin
        dir_d = 1'b0;
        cnt_d = at_top ? CW'(1) : cnt_q + CW'(1);
      end else if (dir_q) begin
        if (at_one) begin
          dir_d = 1'b0;
          cnt_d = mod_gt1 ? CW'(2) : CW'(1);
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end else if (at_top) begin
        dir_d = mod_gt1;
        cnt_d = mod_gt1 ? cnt_q - CW'(1) : CW'(1);
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
    load_o = step_i && (cnt_d == CW'(1));
  end

  always_comb begin
    top_ev = step_i && at_top;
    one_ev = step_i && at_one;
    if (updown_i) begin
      set_ev = one_ev || (both_ev_i && top_ev);
    end else begin
      set_ev = top_ev;
    end
    if (set_ev) begin
      flag_d = 1'b1;
    end else if (flag_clr_i) begin
      flag_d = 1'b0;
    end else begin
      flag_d = flag_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= CW'(1);
      dir_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (step_i) begin
        cnt_q <= cnt_d;
        dir_q <= dir_d;
      end
      flag_q <= flag_d;
    end
  end

  assign cnt_o      = cnt_q;
  assign dir_down_o = dir_q;
  assign flag_o     = flag_q;

endmodule

// File: rtl/tbc_chan.sv
module tbc_chan
  import tbc_pkg::*;
#(
  parameter int unsigned CW          = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              edge_both_i,
  input  logic              edge_rise_i,
  input  logic              ext_pin_i,
  input  logic              mod_wr_i,
  input  logic [CW-1:0]     mod_wdata_i,
  input  logic              flag_clr_i,
  output logic [CW-1:0]     cnt_o,
  output logic              dir_down_o,
  output logic              flag_o,
  output logic [CW-1:0]     mod_act_o
);

  mode_dec_t     dec;
  logic          tick;
  logic          step;
  logic          load;
  logic [CW-1:0] mod_act;

  tbc_mode_dec u_dec (
    .mode_i (mode_i),
    .dec_o  (dec)
  );

  tbc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pin_i     (ext_pin_i),
    .sel_ext_i (dec.ext_clk),
    .both_i    (edge_both_i),
    .rise_i    (edge_rise_i),
    .tick_o    (tick)
  );

  assign step = tick && dec.valid;

  tbc_modulus_buf #(.CW(CW)) u_mod (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (mod_wr_i),
    .wdata_i (mod_wdata_i),
    .load_i  (load),
    .act_o   (mod_act)
  );

  tbc_count_core #(.CW(CW)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_i     (step),
    .updown_i   (dec.updown),
    .both_ev_i  (dec.both_ev),
    .flag_clr_i (flag_clr_i),
    .mod_i      (mod_act),
    .load_o     (load),
    .cnt_o      (cnt_o),
    .dir_down_o (dir_down_o),
    .flag_o     (flag_o)
  );

  assign mod_act_o = mod_act;

endmodule

// File: rtl/tbc_chan_chk.sv
module tbc_chan_chk #(
  parameter int unsigned CW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [6:0]    mode_i,
  input logic          flag_clr_i,
  input logic [CW-1:0] cnt_o,
  input logic          dir_down_o,
  input logic          flag_o,
  input logic [CW-1:0] mod_act_o
);

  logic saw_int;
  logic tri_int;
  logic code_ok;

  always_comb begin
    saw_int = (mode_i == 7'b1010000);
    tri_int = (mode_i[6:2] == 5'b10101) && !mode_i[0];
    code_ok = (mode_i[6:1] == 6'b101000) || (mode_i[6:2] == 5'b10101);
  end

  AST_CNT_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o >= CW'(1)) && (cnt_o <= mod_act_o)); // R1

  AST_MOD_SWAP_AT_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mod_act_o) |-> (cnt_o == CW'(1))); // R2

  AST_SAW_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (saw_int && cnt_o == mod_act_o) |=> (cnt_o == CW'(1))); // R3

  AST_TRI_DESCENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tri_int && dir_down_o && cnt_o > CW'(1)) |=> (cnt_o == $past(cnt_o) - CW'(1))); // R4

  AST_RESERVED_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !code_ok |=> ($stable(cnt_o) && $stable(mod_act_o) && $stable(dir_down_o))); // R8

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !flag_clr_i) |=> flag_o); // R9

endmodule

bind tbc_chan tbc_chan_chk #(.CW(CW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mode_i     (mode_i),
  .flag_clr_i (flag_clr_i),
  .cnt_o      (cnt_o),
  .dir_down_o (dir_down_o),
  .flag_o     (flag_o),
  .mod_act_o  (mod_act_o)
);

// File: tb/tbc_chan_bench.sv
`timescale 1ns/1ps
module tbc_chan_bench;

  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [6:0]    mode = 7'b0;
  logic          both = 1'b0;
  logic          rise = 1'b1;
  logic          pin = 1'b0;
  logic          wr = 1'b0;
  logic [CW-1:0] wdata = '0;
  logic          clr = 1'b0;
  logic [CW-1:0] cnt;
  logic          dir;
  logic          flag;
  logic [CW-1:0] act;

  int    n_vec = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;
  string cur_req = "R10";

  always #5 clk = ~clk;

  tbc_chan #(.CW(CW)) u_tbc_chan (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .edge_both_i(both),
    .edge_rise_i(rise), .ext_pin_i(pin), .mod_wr_i(wr), .mod_wdata_i(wdata),
    .flag_clr_i(clr), .cnt_o(cnt), .dir_down_o(dir), .flag_o(flag),
    .mod_act_o(act)
  );

  // behavioural reference model
  int m_cnt, m_dir, m_flag, m_a1, m_a2;
  bit hist [3];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 1; m_dir = 0; m_flag = 0; m_a1 = 1; m_a2 = 1;
      hist[0] = 0; hist[1] = 0; hist[2] = 0;
    end else begin
      bit valid, tri_m, bev, ext, ev, step, setf;
      int nc, nd;
      valid = (mode[6:1] == 6'b101000) || (mode[6:2] == 5'b10101);
      tri_m = mode[2];
      bev   = mode[1];
      ext   = mode[0];
      if (both) ev = hist[1] != hist[2];
      else if (rise) ev = hist[1] && !hist[2];
      else ev = !hist[1] && hist[2];
      step = valid && (ext ? ev : 1'b1);
      nc = m_cnt; nd = m_dir; setf = 0;
      if (step) begin
        if (!tri_m) begin
          setf = (m_cnt == m_a1);
          nd = 0;
          nc = (m_cnt == m_a1) ? 1 : m_cnt + 1;
        end else begin
          setf = (m_cnt == 1) || (bev && m_cnt == m_a1);
          if (m_dir == 1) begin
            if (m_cnt == 1) begin nd = 0; nc = (m_a1 > 1) ? 2 : 1; end
            else nc = m_cnt - 1;
          end else if (m_cnt == m_a1) begin
            if (m_a1 > 1) begin nd = 1; nc = m_cnt - 1; end
            else nc = 1;
          end else nc = m_cnt + 1;
        end
        if (nc == 1) m_a1 = m_a2;
      end
      if (setf) m_flag = 1;
      else if (clr) m_flag = 0;
      m_cnt = nc; m_dir = nd;
      if (wr) m_a2 = (wdata == 0) ? 1 : int'(wdata);
      hist[2] = hist[1]; hist[1] = hist[0]; hist[0] = pin;
    end
  end

  task automatic chk(input bit ok, input string req, input int a, input int e);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, a, e, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(int'(cnt) == m_cnt, {cur_req, " cnt"}, int'(cnt), m_cnt);
      chk(int'(dir) == m_dir, {cur_req, " dir"}, int'(dir), m_dir);
      chk(int'(flag) == m_flag, {cur_req, " flag"}, int'(flag), m_flag);
      chk(int'(act) == m_a1, {cur_req, " modulus"}, int'(act), m_a1);
      chk(cnt >= 1 && cnt <= act, "R1 window", int'(cnt), int'(act));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_mod(input int v);
    @(negedge clk); wr = 1'b1; wdata = CW'(v);
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic run_clr(input int n, input int every);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); clr = (i % every == every - 1);
    end
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic wait_cnt(input int v);
    for (int i = 0; i < 200 && int'(cnt) != v; i++) @(negedge clk);
  endtask

  task automatic pin_run(input int n, input int half);
    for (int i = 0; i < n; i++) begin
      cyc(half); pin = ~pin;
    end
  endtask

  initial begin
    int held, per;
    cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cnt == 1 && act == 1 && !dir && !flag, "R10 reset", int'(cnt), 1);

    // sawtooth, internal
    cur_req = "R3";
    mode = 7'b1010000;
    wr_mod(5);
    cyc(20);
    wait_cnt(5); @(negedge clk);
    chk(cnt == 1, "R3 wrap at modulus", int'(cnt), 1);

    // staging write mid-cycle
    cur_req = "R2";
    wait_cnt(2);
    wr_mod(3);
    chk(act == 5, "R2 modulus held mid-cycle", int'(act), 5);
    wait_cnt(1);
    chk(act == 3, "R2 modulus loaded at one", int'(act), 3);
    cyc(12);

    // zero write
    cur_req = "R11";
    wr_mod(0);
    cyc(8);
    chk(act == 1, "R11 zero stored as one", int'(act), 1);

    // reserved freeze and resume
    cur_req = "R8";
    wr_mod(6);
    cyc(3);
    wait_cnt(4);
    mode = 7'b1010011;
    wr_mod(2);
    cyc(10);
    chk(cnt == 4, "R8 count frozen", int'(cnt), 4);
    chk(act == 6, "R8 modulus frozen", int'(act), 6);
    mode = 7'b0000000;
    cyc(5);
    chk(cnt == 4, "R8 count frozen code zero", int'(cnt), 4);
    cur_req = "R5";
    held = int'(cnt);
    mode = 7'b1010000;
    @(negedge clk);
    chk(int'(cnt) == held + 1, "R5 resume from held", int'(cnt), held + 1);
    wr_mod(6);
    cyc(14);

    // flag clear and set-wins
    cur_req = "R9";
    wait_cnt(2);
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    chk(!flag, "R9 clear", int'(flag), 0);
    cyc(2);
    chk(!flag, "R9 stays clear", int'(flag), 0);
    wait_cnt(6);
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    chk(flag, "R9 set wins over clear", int'(flag), 1);
    run_clr(20, 3);

    // triangle single event
    cur_req = "R4";
    mode = 7'b1010100;
    wr_mod(5);
    cyc(20);
    wait_cnt(1);
    per = 0;
    do begin @(negedge clk); per++; end while (cnt != 1 && per < 40);
    chk(per == 8, "R4 triangle period", per, 8);
    cur_req = "R6";
    run_clr(30, 4);
    mode = 7'b1010110;
    run_clr(30, 3);
    wr_mod(1);
    cyc(10);
    wr_mod(4);
    run_clr(20, 2);

    // external stepping
    cur_req = "R7";
    mode = 7'b1010001;
    both = 1'b0; rise = 1'b1;
    cyc(5);
    held = int'(cnt);
    cyc(6);
    chk(int'(cnt) == held, "R7 no pin edge no step", int'(cnt), held);
    pin = 1'b1;
    cyc(2);
    chk(int'(cnt) == held, "R7 two-edge latency hold", int'(cnt), held);
    @(negedge clk);
    chk(int'(cnt) != held, "R7 step after sync", int'(cnt), held + 1);
    pin_run(16, 3);
    rise = 1'b0;
    pin_run(16, 4);
    both = 1'b1;
    pin_run(16, 3);
    mode = 7'b1010111;
    pin_run(30, 3);
    mode = 7'b1010101; both = 1'b0; rise = 1'b1;
    pin_run(20, 5);
    mode = 7'b1010000;
    cyc(10);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule